// File: doc/BRIEF.md
# GPIO controller with interrupt logic

This peripheral serves sixteen general-purpose lines from a small 16-bit register bus. Each line can be an output or an input. An output is driven from a held value that software changes through a write-one-to-set port and a write-one-to-clear port, so no read-modify-write is needed. An input is sampled through a two-flop synchronizer, and its level can be read back at any time. The block drives only output-enable and output-value vectors; the pad drivers and pin multiplexing sit outside it.

Any line can raise an interrupt. It can fire on an active-high level, an active-low level, a rising edge, a falling edge, or both edges. A line takes part only while its block bit is 0 and its enable bit is 1. When a trigger occurs on such a line, a sticky pending bit is set. The pending bits of allowed lines form the masked status, and software clears them by writing ones. One interrupt output is the OR of the whole masked status. To acknowledge, a handler reads the status and writes the same word back to the clear port.

Bus access works as follows. A write takes effect on the clock edge where `bus_we` is high. A read registers its data on the edge where `bus_re` is high, and the data is held for the following cycle. Read data is zero in any cycle that follows no read.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, all lines are inputs, the output value is 0, the block register reads 0xFFFF, the enable register reads 0, nothing is pending and `irq` is low.
- R2: The direction register at byte offset 0x00 drives `out_en`. A 1 in bit n makes line n an output and a 0 makes it an input. `out_en` changes only on a write to that offset.
- R3: Writing a word to the set port (0x18) drives high every output whose bit is 1. Writing to the clear port (0x1C) drives low every output whose bit is 1. Bits written as 0 keep their value. The output-data register at 0x20 reads and writes the whole output value, which appears on `out_val`.
- R4: The data-in register at 0x14 returns each line's level after two synchronizer stages. A read issued one cycle after a pin change still returns the old level, and a read issued two cycles after returns the new one.
- R5: When the level-select bit (0x04) is 1, the line triggers on its level. A polarity bit (0x08) of 1 means active-high and 0 means active-low. A level that is still active sets its pending bit again in the cycle after a clear.
- R6: When the level-select bit is 0, the line triggers on edges. A 1 in the rising-edge enable register (0x0C) triggers on a 0 to 1 change, and a 1 in the falling-edge enable register (0x10) triggers on a 1 to 0 change. A change whose edge is not enabled records nothing. An edge event stays pending after the pin returns.
- R7: With both edge-enable bits set, a line triggers on either edge.
- R8: A trigger is recorded only while the line's block bit (0x28) is 0 and its enable bit (0x2C) is 1. A trigger that occurs while the line is disallowed leaves nothing pending when the line is later allowed.
- R9: Writing ones to the interrupt-clear port (0x34) clears the matching pending bits, and bits written as 0 leave theirs alone. A clear wins over a trigger in the same cycle.
- R10: `irq` is high exactly when the masked status register (0x30) is non-zero.
- R11: Reads of the set, clear and interrupt-clear ports return 0. Reads of any unmapped offset (for example 0x24 and 0x3C) return 0, and writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the accessed register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | NLINES (16) | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | NLINES (16) | Registered read data |
| pin_in | input | NLINES (16) | Pin levels, asynchronous |
| out_en | output | NLINES (16) | Per-line output enable |
| out_val | output | NLINES (16) | Per-line output value |
| irq | output | 1 | Combined interrupt |

## Verification
The properties assume that `bus_we` and `bus_re` are never high in the same cycle. They also assume that address and write data are steady around the clock edge. The bench drives each strobe alone for exactly one cycle and changes bus and pin inputs only on the falling edge, so every access is a clean single-cycle transaction. Pin changes are spaced at least three cycles apart, which lets each edge pass through the synchronizer and into the pending bits before the next change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam logic [7:0] OFS_DIR   = 8'h00;
  localparam logic [7:0] OFS_LSEL  = 8'h04;
  localparam logic [7:0] OFS_LPOL  = 8'h08;
  localparam logic [7:0] OFS_RISE  = 8'h0C;
  localparam logic [7:0] OFS_FALL  = 8'h10;
  localparam logic [7:0] OFS_DIN   = 8'h14;
  localparam logic [7:0] OFS_OSET  = 8'h18;
  localparam logic [7:0] OFS_OCLR  = 8'h1C;
  localparam logic [7:0] OFS_ODATA = 8'h20;
  localparam logic [7:0] OFS_BLK   = 8'h28;
  localparam logic [7:0] OFS_ENA   = 8'h2C;
  localparam logic [7:0] OFS_MSTAT = 8'h30;
  localparam logic [7:0] OFS_ICLR  = 8'h34;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DIR, SEL_LSEL, SEL_LPOL, SEL_RISE, SEL_FALL, SEL_DIN,
    SEL_OSET, SEL_OCLR, SEL_ODATA, SEL_BLK, SEL_ENA, SEL_MSTAT, SEL_ICLR
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
    case (ofs)
      OFS_DIR:   return SEL_DIR;
      OFS_LSEL:  return SEL_LSEL;
      OFS_LPOL:  return SEL_LPOL;
      OFS_RISE:  return SEL_RISE;
      OFS_FALL:  return SEL_FALL;
      OFS_DIN:   return SEL_DIN;
      OFS_OSET:  return SEL_OSET;
      OFS_OCLR:  return SEL_OCLR;
      OFS_ODATA: return SEL_ODATA;
      OFS_BLK:   return SEL_BLK;
      OFS_ENA:   return SEL_ENA;
      OFS_MSTAT: return SEL_MSTAT;
      OFS_ICLR:  return SEL_ICLR;
      default:   return SEL_NONE;
    endcase
  endfunction

  // Ports that read as zero (R11)
  function automatic logic reads_zero(input reg_sel_e s);
    return (s == SEL_NONE) || (s == SEL_OSET) || (s == SEL_OCLR) || (s == SEL_ICLR);
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NLINES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] cur_lvl,
  output logic [NLINES-1:0] prev_lvl
);
  logic [NLINES-1:0] meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign cur_lvl  = sync_q;
  assign prev_lvl = last_q;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
  parameter int NLINES = 16
) (
  input  logic [NLINES-1:0] lsel,
  input  logic [NLINES-1:0] lpol,
  input  logic [NLINES-1:0] rise_en,
  input  logic [NLINES-1:0] fall_en,
  input  logic [NLINES-1:0] cur_lvl,
  input  logic [NLINES-1:0] prev_lvl,
  output logic [NLINES-1:0] trig_evt
);
  function automatic logic line_trig(input logic is_lvl, input logic pol,
                                     input logic re, input logic fe,
                                     input logic now, input logic was);
    logic lvl_hit, edge_hit;
    lvl_hit  = (now == pol);
    edge_hit = (re & now & ~was) | (fe & ~now & was);
    return is_lvl ? lvl_hit : edge_hit;
  endfunction

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    assign trig_evt[i] = line_trig(lsel[i], lpol[i], rise_en[i], fall_en[i],
                                   cur_lvl[i], prev_lvl[i]);
  end
endmodule

// File: rtl/gpio_pend_status.sv
module gpio_pend_status #(
  parameter int NLINES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] trig_evt,
  input  logic [NLINES-1:0] allow,
  input  logic [NLINES-1:0] clr_vec,
  output logic [NLINES-1:0] pend,
  output logic [NLINES-1:0] mstat
);
  function automatic logic [NLINES-1:0] next_pend(input logic [NLINES-1:0] cur,
                                                  input logic [NLINES-1:0] set,
                                                  input logic [NLINES-1:0] clr);
    return (cur | set) & ~clr;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= next_pend(pend, trig_evt & allow, clr_vec);
  end

  assign mstat = pend & allow;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NLINES = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NLINES-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [NLINES-1:0] bus_rdata,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] out_en,
  output logic [NLINES-1:0] out_val,
  output logic              irq
);
  import gpio_irq_pkg::*;

  typedef logic [NLINES-1:0] vec_t;

  vec_t dir_q, lsel_q, lpol_q, rise_q, fall_q, oval_q, blk_q, ena_q;
  vec_t cur_lvl, prev_lvl, trig_evt, allow, pend, mstat, clr_vec;
  vec_t rdata_d;
  logic up_ok;
  reg_sel_e sel;

  if (ADDR_W > 8) begin : g_wide
    assign up_ok = ~|bus_addr[ADDR_W-1:8];
  end else begin : g_narrow
    assign up_ok = 1'b1;
  end

  assign sel = up_ok ? decode_ofs(bus_addr[7:0]) : SEL_NONE;

  function automatic vec_t next_out(input vec_t cur, input vec_t set_m, input vec_t clr_m);
    return (cur | set_m) & ~clr_m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      lsel_q <= '0;
      lpol_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
      oval_q <= '0;
      blk_q  <= '1;
      ena_q  <= '0;
    end else if (bus_we) begin
      case (sel)
        SEL_DIR:   dir_q  <= bus_wdata;
        SEL_LSEL:  lsel_q <= bus_wdata;
        SEL_LPOL:  lpol_q <= bus_wdata;
        SEL_RISE:  rise_q <= bus_wdata;
        SEL_FALL:  fall_q <= bus_wdata;
        SEL_OSET:  oval_q <= next_out(oval_q, bus_wdata, '0);
        SEL_OCLR:  oval_q <= next_out(oval_q, '0, bus_wdata);
        SEL_ODATA: oval_q <= bus_wdata;
        SEL_BLK:   blk_q  <= bus_wdata;
        SEL_ENA:   ena_q  <= bus_wdata;
        default:   ;
      endcase
    end
  end

  assign clr_vec = (bus_we && sel == SEL_ICLR) ? bus_wdata : '0;
  assign allow   = ~blk_q & ena_q;

  gpio_in_sync #(.NLINES(NLINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .cur_lvl(cur_lvl), .prev_lvl(prev_lvl)
  );

  gpio_trig_detect #(.NLINES(NLINES)) u_trig (
    .lsel(lsel_q), .lpol(lpol_q), .rise_en(rise_q), .fall_en(fall_q),
    .cur_lvl(cur_lvl), .prev_lvl(prev_lvl), .trig_evt(trig_evt)
  );

  gpio_pend_status #(.NLINES(NLINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .trig_evt(trig_evt), .allow(allow),
    .clr_vec(clr_vec), .pend(pend), .mstat(mstat)
  );

  always_comb begin
    case (sel)
      SEL_DIR:   rdata_d = dir_q;
      SEL_LSEL:  rdata_d = lsel_q;
      SEL_LPOL:  rdata_d = lpol_q;
      SEL_RISE:  rdata_d = rise_q;
      SEL_FALL:  rdata_d = fall_q;
      SEL_DIN:   rdata_d = cur_lvl;
      SEL_ODATA: rdata_d = oval_q;
      SEL_BLK:   rdata_d = blk_q;
      SEL_ENA:   rdata_d = ena_q;
      SEL_MSTAT: rdata_d = mstat;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= bus_re ? rdata_d : '0;
  end

  assign out_en  = dir_q;
  assign out_val = oval_q;
  assign irq     = |mstat;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NLINES = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [NLINES-1:0] bus_wdata,
  input logic              bus_re,
  input logic [NLINES-1:0] bus_rdata,
  input logic [NLINES-1:0] out_en,
  input logic [NLINES-1:0] out_val,
  input logic [NLINES-1:0] pend,
  input logic [NLINES-1:0] trig_evt,
  input logic [NLINES-1:0] allow,
  input logic [NLINES-1:0] clr_vec
);
  import gpio_irq_pkg::*;

  logic [7:0] a8;
  logic [NLINES-1:0] rec;
  assign a8  = bus_addr[7:0];
  assign rec = trig_evt & allow & ~clr_vec;

  assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && decode_ofs(a8) == SEL_DIR) |=> $stable(out_en));

  assert_set_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && decode_ofs(a8) == SEL_OSET) |=> ((out_val & $past(bus_wdata)) == $past(bus_wdata)));

  assert_clr_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && decode_ofs(a8) == SEL_OCLR) |=> ((out_val & $past(bus_wdata)) == '0));

  assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rec != '0) |=> ((pend & $past(rec)) == $past(rec)));

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((pend & $past(clr_vec)) == '0));

  assert_zero_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && reads_zero(decode_ofs(a8))) |=> (bus_rdata == '0));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .out_en(out_en), .out_val(out_val), .pend(pend), .trig_evt(trig_evt),
  .allow(allow), .clr_vec(clr_vec)
);

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [15:0] pins = '0;
  logic [15:0] oen, oval;
  logic        irq;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_ctrl #(.NLINES(16), .ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_re(re), .bus_rdata(rdata), .pin_in(pins), .out_en(oen),
    .out_val(oval), .irq(irq)
  );

  // {do_write, offset, write data, expected read}
  localparam int NV = 15;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 8'h00, 16'hA5C3, 16'hA5C3},  // R2 direction
    {1'b1, 8'h04, 16'h00F0, 16'h00F0},  // R5 level select
    {1'b1, 8'h08, 16'h0F0F, 16'h0F0F},  // R5 polarity
    {1'b1, 8'h0C, 16'h1234, 16'h1234},  // R6 rise enable
    {1'b1, 8'h10, 16'h8001, 16'h8001},  // R6 fall enable
    {1'b1, 8'h28, 16'h5555, 16'h5555},  // R8 block
    {1'b1, 8'h2C, 16'hAAAA, 16'hAAAA},  // R8 enable
    {1'b1, 8'h20, 16'h0000, 16'h0000},  // R3 output data
    {1'b1, 8'h18, 16'h0011, 16'h0000},  // R3 set, R11 reads zero
    {1'b0, 8'h20, 16'h0000, 16'h0011},  // R3 after set
    {1'b1, 8'h1C, 16'h0001, 16'h0000},  // R3 clear, R11 reads zero
    {1'b0, 8'h20, 16'h0000, 16'h0010},  // R3 after clear
    {1'b1, 8'h24, 16'hFFFF, 16'h0000},  // R11 unmapped
    {1'b1, 8'h3C, 16'h1234, 16'h0000},  // R11 unmapped
    {1'b1, 8'h34, 16'hFFFF, 16'h0000}   // R11 interrupt clear port
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic set_pins(input logic [15:0] v);
    @(negedge clk);
    pins = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    do_reset();

    // R1 reset state
    chk("R1 out_en", oen, 16'h0000);
    chk("R1 out_val", oval, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);
    bus_rd(8'h28, r); chk("R1 block", r, 16'hFFFF);
    bus_rd(8'h2C, r); chk("R1 enable", r, 16'h0000);
    bus_rd(8'h30, r); chk("R1 status", r, 16'h0000);

    // register table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) bus_wr(VEC[i][39:32], VEC[i][31:16]);
      bus_rd(VEC[i][39:32], r);
      chk($sformatf("table row %0d (R2/R3/R11)", i), r, VEC[i][15:0]);
    end
    chk("R2 out_en port", oen, 16'hA5C3);
    chk("R3 out_val port", oval, 16'h0010);
    bus_rd(8'h00, r); chk("R11 unmapped write left direction", r, 16'hA5C3);

    // interrupt tests from a clean state
    do_reset();
    bus_wr(8'h2C, 16'hFFFF);
    bus_wr(8'h28, 16'h0000);
    bus_wr(8'h0C, 16'h0005);
    bus_wr(8'h10, 16'h0006);

    // R6 rising-only and falling-only
    set_pins(16'h0001);
    chk("R6 rise irq", {15'd0, irq}, 16'h0001);
    bus_rd(8'h30, r); chk("R6 rise status", r, 16'h0001);
    set_pins(16'h0000);
    bus_rd(8'h30, r); chk("R6 sticky after fall", r, 16'h0001);
    bus_wr(8'h34, 16'h0001);
    bus_rd(8'h30, r); chk("R6 cleared", r, 16'h0000);
    set_pins(16'h0002);
    bus_rd(8'h30, r); chk("R6 rise ignored line1", r, 16'h0000);
    set_pins(16'h0000);
    bus_rd(8'h30, r); chk("R6 fall line1", r, 16'h0002);
    bus_wr(8'h34, 16'h0002);

    // R7 both edges on line 2
    set_pins(16'h0004);
    bus_rd(8'h30, r); chk("R7 rise", r, 16'h0004);
    bus_wr(8'h34, 16'h0004);
    set_pins(16'h0000);
    bus_rd(8'h30, r); chk("R7 fall", r, 16'h0004);
    bus_wr(8'h34, 16'h0004);
    bus_rd(8'h30, r); chk("R7 cleared", r, 16'h0000);

    // R5 level: line4 active-high, line5 active-low
    set_pins(16'h0020);
    bus_wr(8'h08, 16'h0010);
    bus_wr(8'h04, 16'h0030);
    bus_rd(8'h30, r); chk("R5 both inactive", r, 16'h0000);
    set_pins(16'h0030);
    bus_rd(8'h30, r); chk("R5 high level", r, 16'h0010);
    bus_wr(8'h34, 16'h0010);
    bus_rd(8'h30, r); chk("R5 reasserts after clear", r, 16'h0010);
    set_pins(16'h0010);
    bus_rd(8'h30, r); chk("R5 low level", r, 16'h0030);
    set_pins(16'h0020);
    bus_wr(8'h34, 16'h0030);
    bus_rd(8'h30, r); chk("R5 cleared when inactive", r, 16'h0000);
    bus_wr(8'h04, 16'h0000);

    // R8 block and enable gating on line 0
    bus_wr(8'h28, 16'h0001);
    set_pins(16'h0021);
    chk("R8 blocked irq", {15'd0, irq}, 16'h0000);
    bus_wr(8'h28, 16'h0000);
    bus_rd(8'h30, r); chk("R8 blocked event not recorded", r, 16'h0000);
    bus_wr(8'h2C, 16'hFFFE);
    set_pins(16'h0020);
    set_pins(16'h0021);
    bus_wr(8'h2C, 16'hFFFF);
    bus_rd(8'h30, r); chk("R8 disabled event not recorded", r, 16'h0000);
    set_pins(16'h0020);
    set_pins(16'h0021);
    bus_rd(8'h30, r); chk("R8 allowed event", r, 16'h0001);

    // R9 clear with zeros has no effect
    bus_wr(8'h34, 16'hFFFE);
    bus_rd(8'h30, r); chk("R9 zero bits keep", r, 16'h0001);
    bus_wr(8'h34, 16'h0001);
    bus_rd(8'h30, r); chk("R9 one clears", r, 16'h0000);
    chk("R9 irq low", {15'd0, irq}, 16'h0000);

    // R10 irq as OR of status
    set_pins(16'h0020);
    set_pins(16'h0025);
    bus_rd(8'h30, r); chk("R10 two pending", r, 16'h0005);
    chk("R10 irq high", {15'd0, irq}, 16'h0001);
    bus_wr(8'h34, 16'h0001);
    chk("R10 irq still high", {15'd0, irq}, 16'h0001);
    bus_wr(8'h34, 16'h0004);
    chk("R10 irq low", {15'd0, irq}, 16'h0000);

    // R4 data-in and its latency
    set_pins(16'hBEEF);
    bus_rd(8'h14, r); chk("R4 data in", r, 16'hBEEF);
    @(negedge clk);
    pins = 16'h1234;
    bus_rd(8'h14, r); chk("R4 old level one cycle after", r, 16'hBEEF);
    bus_rd(8'h14, r); chk("R4 new level two cycles after", r, 16'h1234);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule